// File: doc/BRIEF.md
# Keyed Windowed Watchdog

This block supervises software by demanding a service write at regular intervals. It counts instruction-cycle ticks since the last restart of its window. Software restarts the window by writing an 8-bit service word. The word carries a window-size code, a clock-monitor enable and a 5-bit key. A write that arrives too soon, carries a wrong key or disagrees with the locked configuration is a violation. A window that runs out with no service is also a violation. Each violation produces a one-cycle low pulse on the error output and restarts the window.

The first service after reset does two things. It proves the key, and it fixes the window code and the monitor enable for the rest of the run. Every later service must repeat all three fields exactly. The counter pauses while the core is halted or idle. Leaving idle restarts the window on its own. A separate clock-fail input is watched at all times while monitoring is on, including during halt and idle.

Top module: `kwd_guard`

## Requirements
- R1: While `rst_n` is low, `wd_err_n_o` stays high whatever the other inputs do.
- R2: After reset, the read port returns 8'hE0: window code 2'b11 and monitor enabled. With no service, a timeout occurs after `BASE_LIM*8` counted ticks.
- R3: Only the first key-correct service after reset loads the window code and the monitor enable. Later writes never change the value read back for them.
- R4: The first service must carry key 5'b01100. Any other key raises an error. The lower limit does not apply to this first service.
- R5: Once the configuration is locked, a service raises an error if its key, its window code or its monitor bit differs from the expected value.
- R6: Once locked, a service seen with fewer than `LOW_LIM` counted ticks since the last restart is an error. A service with `LOW_LIM` up to limit-1 ticks is valid and restarts the window. When the count would reach the limit with no service, a timeout error is raised.
- R7: The read word is {window[7:6], monitor[5], key[4:0]}, and its key field always reads 5'b00000.
- R8: While `halt_i` or `idle_i` is high, ticks are not counted and no timeout can occur.
- R9: The first cycle in which `idle_i` is low after being high restarts the window, so the lower limit applies again.
- R10: Window code c gives an upper limit of `BASE_LIM << c` ticks (codes 2'b00 to 2'b11).
- R11: With monitoring enabled, a rising edge on `clk_fail_i` gives one error pulse, even during halt. With monitoring disabled, it gives none.
- R12: Each violation gives a one-cycle low pulse on the registered error output one clock later, and the window restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Instruction-cycle tick enable |
| halt_i | input | 1 | Core halted; counter frozen |
| idle_i | input | 1 | Core idle; counter frozen, exit restarts window |
| wr_en_i | input | 1 | Service write strobe |
| wr_data_i | input | 8 | Service word {window, monitor, key} |
| rd_data_o | output | 8 | Service register read value, key masked |
| clk_fail_i | input | 1 | Clock-loss indication from an external detector |
| wd_err_n_o | output | 1 | Registered active-low error pulse |

## Verification
The checker takes two things for granted. The tick count never goes past the selected limit, and a service strobe is a single-cycle pulse with stable data. The bench drives every write for exactly one clock at the falling edge and spaces services by counted waits. This puts each service either clearly inside or exactly at an edge of the window. It keeps `clk_fail_i` low across reset release and raises halt during clock-fail pulses, so a timeout cannot mix with the monitor pulse.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   localparam int KEY_W = 5;
   localparam int WIN_W = 2;

   typedef struct packed {
      logic [WIN_W-1:0] win;
      logic             mon;
      logic [KEY_W-1:0] key;
   } svc_word_t;

   localparam logic [WIN_W-1:0] WIN_RESET = 2'b11;
endpackage

// File: rtl/kwd_cfg.sv
module kwd_cfg
   import kwd_pkg::*;
#(
   parameter logic [KEY_W-1:0] KEY = 5'b01100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             svc_i,
   input  svc_word_t        word_i,
   output logic             locked_o,
   output logic [WIN_W-1:0] win_o,
   output logic             mon_o,
   output logic             svc_bad_o
);
   logic             locked_q;
   logic [WIN_W-1:0] win_q;
   logic             mon_q;
   logic             key_ok;
   logic             fields_ok;

   assign key_ok    = (word_i.key == KEY);
   assign fields_ok = (word_i.win == win_q) && (word_i.mon == mon_q);
   assign svc_bad_o = svc_i && !(key_ok && (!locked_q || fields_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         win_q    <= WIN_RESET;
         mon_q    <= 1'b1;
      end else if (svc_i && !locked_q && key_ok) begin
         locked_q <= 1'b1;
         win_q    <= word_i.win;
         mon_q    <= word_i.mon;
      end
   end

   assign locked_o = locked_q;
   assign win_o    = win_q;
   assign mon_o    = mon_q;
endmodule

// File: rtl/kwd_timer.sv
module kwd_timer
   import kwd_pkg::*;
#(
   parameter int BASE_LIM = 8192,
   parameter int LOW_LIM  = 2048,
   parameter int CNT_W    = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic             svc_i,
   input  logic             locked_i,
   input  logic [WIN_W-1:0] win_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] lim_o,
   output logic             early_o,
   output logic             tmo_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic             step;

   assign lim     = CNT_W'(BASE_LIM) << win_i;
   assign step    = run_i && tick_i;
   assign early_o = svc_i && locked_i && (cnt_q < CNT_W'(LOW_LIM));
   assign tmo_o   = step && !restart_i && (cnt_q == lim - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (restart_i || tmo_o) cnt_q <= '0;
      else if (step)              cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt_o = cnt_q;
   assign lim_o = lim;
endmodule

// File: rtl/kwd_clkmon.sv
module kwd_clkmon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fail_i,
   input  logic en_i,
   output logic hit_o
);
   logic fail_s;
   logic fail_d;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign fail_s = fail_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-2+((SYNC_STAGES>1)?0:1):0], fail_i};
         end
         assign fail_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fail_d <= 1'b0;
      else        fail_d <= fail_s;
   end

   assign hit_o = en_i && fail_s && !fail_d;
endmodule

// File: rtl/kwd_guard.sv
module kwd_guard
   import kwd_pkg::*;
#(
   parameter int               BASE_LIM    = 8192,
   parameter int               LOW_LIM     = 2048,
   parameter int               SYNC_STAGES = 2,
   parameter logic [KEY_W-1:0] KEY         = 5'b01100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       halt_i,
   input  logic       idle_i,
   input  logic       wr_en_i,
   input  logic [7:0] wr_data_i,
   output logic [7:0] rd_data_o,
   input  logic       clk_fail_i,
   output logic       wd_err_n_o
);
   localparam int CNT_W = $clog2(BASE_LIM) + 4;

   initial begin
      assert (LOW_LIM > 0 && LOW_LIM < BASE_LIM)
         else $error("kwd_guard: LOW_LIM must lie in 1..BASE_LIM-1");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("kwd_guard: SYNC_STAGES must lie in 0..4");
   end

   svc_word_t        word;
   logic             locked_w;
   logic [WIN_W-1:0] win_w;
   logic             mon_w;
   logic             svc_bad;
   logic             early;
   logic             tmo;
   logic             cm_hit;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] lim_w;
   logic             idle_q;
   logic             idle_exit;
   logic             err_n_q;

   assign word      = svc_word_t'(wr_data_i);
   assign idle_exit = idle_q && !idle_i;

   kwd_cfg #(.KEY(KEY)) cfg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .svc_i    (wr_en_i),
      .word_i   (word),
      .locked_o (locked_w),
      .win_o    (win_w),
      .mon_o    (mon_w),
      .svc_bad_o(svc_bad)
   );

   kwd_timer #(.BASE_LIM(BASE_LIM), .LOW_LIM(LOW_LIM), .CNT_W(CNT_W)) tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .run_i    (!halt_i && !idle_i),
      .restart_i(wr_en_i || idle_exit),
      .svc_i    (wr_en_i),
      .locked_i (locked_w),
      .win_i    (win_w),
      .cnt_o    (cnt_w),
      .lim_o    (lim_w),
      .early_o  (early),
      .tmo_o    (tmo)
   );

   kwd_clkmon #(.SYNC_STAGES(SYNC_STAGES)) cm_i (
      .clk   (clk),
      .rst_n (rst_n),
      .fail_i(clk_fail_i),
      .en_i  (mon_w),
      .hit_o (cm_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q  <= 1'b0;
         err_n_q <= 1'b1;
      end else begin
         idle_q  <= idle_i;
         err_n_q <= !(svc_bad || early || tmo || cm_hit);
      end
   end

   assign wd_err_n_o = err_n_q;
   assign rd_data_o  = {win_w, mon_w, {KEY_W{1'b0}}};
endmodule

// File: rtl/kwd_guard_chk.sv
module kwd_guard_chk #(
   parameter int         CNT_W   = 17,
   parameter int         LOW_LIM = 2048,
   parameter logic [4:0] KEY     = 5'b01100
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en_i,
   input logic [7:0]       wr_data_i,
   input logic             halt_i,
   input logic             idle_i,
   input logic [7:0]       rd_data_o,
   input logic             wd_err_n_o,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] lim,
   input logic             locked
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> wd_err_n_o);

   // R3
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked && $past(locked) |-> $stable(rd_data_o[7:5]));

   // R5
   bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i && (wr_data_i[4:0] != KEY) |=> !wd_err_n_o);

   // R5
   field_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i && locked && (wr_data_i[7:5] != rd_data_o[7:5]) |=> !wd_err_n_o);

   // R6
   early_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i && locked && (cnt_q < CNT_W'(LOW_LIM)) |=> !wd_err_n_o);

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < lim);

   // R8
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_i || idle_i) && !wr_en_i |=> cnt_q == $past(cnt_q));

   // R9
   idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle_i) |=> cnt_q == '0);
endmodule

bind kwd_guard kwd_guard_chk #(.CNT_W(CNT_W), .LOW_LIM(LOW_LIM), .KEY(KEY)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en_i   (wr_en_i),
   .wr_data_i (wr_data_i),
   .halt_i    (halt_i),
   .idle_i    (idle_i),
   .rd_data_o (rd_data_o),
   .wd_err_n_o(wd_err_n_o),
   .cnt_q     (cnt_w),
   .lim       (lim_w),
   .locked    (locked_w)
);

// File: tb/kwd_guard_tb_top.sv
module kwd_guard_tb_top;
   localparam int         BASE = 64;
   localparam int         LOW  = 16;
   localparam logic [4:0] KOK  = 5'b01100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b1;
   logic       halt_i = 1'b0;
   logic       idle_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic       clk_fail_i = 1'b0;
   logic [7:0] rd_data_o;
   logic       wd_err_n_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   kwd_guard #(.BASE_LIM(BASE), .LOW_LIM(LOW), .SYNC_STAGES(2), .KEY(KOK)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .halt_i(halt_i), .idle_i(idle_i),
      .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
      .clk_fail_i(clk_fail_i), .wd_err_n_o(wd_err_n_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic svc(input logic [1:0] w, input logic m, input logic [4:0] k, output logic e);
      wr_en_i   = 1'b1;
      wr_data_i = {w, m, k};
      @(negedge clk);
      wr_en_i   = 1'b0;
      e = wd_err_n_o;
   endtask

   task automatic count_lows(input int n, output int c);
      c = 0;
      repeat (n) begin
         @(negedge clk);
         if (!wd_err_n_o) c++;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; halt_i = 1'b0; idle_i = 1'b0; clk_fail_i = 1'b0; wr_en_i = 1'b0;
      wait_n(3);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      int c;
      rst_n = 1'b0;
      clk_fail_i = 1'b1;
      wr_en_i = 1'b1; wr_data_i = 8'hFF;
      count_lows(5, c);
      check("R1 quiet in reset", c, 0);
      wr_en_i = 1'b0; clk_fail_i = 1'b0;
      wait_n(3);
      rst_n = 1'b1;
      check("R1 err high after reset", wd_err_n_o, 1);
      check("R2 reset read value", rd_data_o, 8'hE0);
   endtask

   task automatic t_first_and_lock();
      logic e;
      do_reset();
      svc(2'b11, 1'b1, 5'b00000, e);
      check("R4 first bad key", e, 0);
      check("R3 unlocked after bad key", rd_data_o, 8'hE0);
      svc(2'b00, 1'b1, KOK, e);
      check("R4 first good key no lower limit", e, 1);
      check("R7 read masks key", rd_data_o, 8'h20);
      wait_n(20); svc(2'b01, 1'b1, KOK, e);
      check("R5 window mismatch", e, 0);
      check("R3 config locked", rd_data_o, 8'h20);
      wait_n(20); svc(2'b00, 1'b0, KOK, e);
      check("R5 monitor mismatch", e, 0);
      wait_n(20); svc(2'b00, 1'b1, 5'b01101, e);
      check("R5 key mismatch", e, 0);
      wait_n(20); svc(2'b00, 1'b1, KOK, e);
      check("R5 full match", e, 1);
   endtask

   task automatic t_window();
      logic e;
      wait_n(LOW - 1); svc(2'b00, 1'b1, KOK, e);
      check("R6 early by one", e, 0);
      wait_n(LOW); svc(2'b00, 1'b1, KOK, e);
      check("R6 at lower limit", e, 1);
      wait_n(BASE - 1); svc(2'b00, 1'b1, KOK, e);
      check("R6 at upper limit", e, 1);
      wait_n(BASE - 1);
      check("R6 no timeout yet", wd_err_n_o, 1);
      wait_n(1);
      check("R6 timeout", wd_err_n_o, 0);
      wait_n(1);
      check("R12 one cycle pulse", wd_err_n_o, 1);
      wait_n(LOW - 2); svc(2'b00, 1'b1, KOK, e);
      check("R12 window restarted after timeout", e, 0);
   endtask

   task automatic t_sizes();
      logic e;
      do_reset();
      wait_n(BASE * 8 - 1);
      check("R2 default window no timeout", wd_err_n_o, 1);
      wait_n(1);
      check("R10 default window timeout", wd_err_n_o, 0);
      do_reset();
      svc(2'b01, 1'b1, KOK, e);
      wait_n(BASE * 2 - 1);
      check("R10 code 01 no timeout", wd_err_n_o, 1);
      wait_n(1);
      check("R10 code 01 timeout", wd_err_n_o, 0);
   endtask

   task automatic t_halt();
      logic e;
      int c;
      do_reset();
      svc(2'b00, 1'b1, KOK, e);
      wait_n(40);
      halt_i = 1'b1;
      count_lows(300, c);
      check("R8 no timeout while halted", c, 0);
      halt_i = 1'b0;
      wait_n(BASE - 41);
      check("R8 count resumed", wd_err_n_o, 1);
      wait_n(1);
      check("R8 timeout after resume", wd_err_n_o, 0);
   endtask

   task automatic t_idle();
      logic e;
      int c;
      do_reset();
      svc(2'b00, 1'b1, KOK, e);
      wait_n(40);
      idle_i = 1'b1;
      count_lows(50, c);
      check("R8 no timeout while idle", c, 0);
      idle_i = 1'b0;
      wait_n(1);
      wait_n(5); svc(2'b00, 1'b1, KOK, e);
      check("R9 idle exit restarts window", e, 0);
   endtask

   task automatic t_clkmon();
      logic e;
      int c;
      do_reset();
      svc(2'b00, 1'b1, KOK, e);
      halt_i = 1'b1;
      clk_fail_i = 1'b1;
      count_lows(12, c);
      check("R11 monitor pulse in halt", c, 1);
      clk_fail_i = 1'b0;
      wait_n(4);
      do_reset();
      svc(2'b00, 1'b0, KOK, e);
      halt_i = 1'b1;
      clk_fail_i = 1'b1;
      count_lows(12, c);
      check("R11 monitor disabled", c, 0);
      clk_fail_i = 1'b0;
      halt_i = 1'b0;
   endtask

   initial begin
      wait_n(1);
      t_reset();
      t_first_and_lock();
      t_window();
      t_sizes();
      t_halt();
      t_idle();
      t_clkmon();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule